// File: doc/BRIEF.md
# Mute Output Pin Controller

This block drives one external pin that switches analog mute circuitry. The pin floats while the device is still powering up and whenever software holds the power-down control at 1. Once the device is active, the pin is driven by one of two sources. In manual mode it copies a user level bit. In automatic mode it goes high when every DAC input stream has been silent for a long run of samples, or when the serial port reports a clock fault.

The automatic path watches six sample streams, qualified by a common valid strobe. A channel counts as silent only after a long unbroken run of zero samples, so brief gaps in the audio do not produce a mute. After a clock fault clears, the mute is held for a further fixed number of sample strobes so that the DACs can settle.

When the device leaves the inactive state, the pin is first driven low. It stays low until the first sample strobe has been taken, so it never floats while control changes hands. The detection of clock faults and the DAC data path are outside this block.

Top module: `mute_pin_ctrl`

## Requirements
- R1: While `powerUpDone` is 0, `mutePinOe` is 0 from the next clock edge on, and `mutePin` is 0 whenever `mutePinOe` is 0.
- R2: While `powerDown` is 1, `mutePinOe` is 0 from the next clock edge on, whatever the value of `powerUpDone`.
- R3: On the first edge at which `powerDown` is 0 and `powerUpDone` is 1, `mutePinOe` rises with `mutePin` at 0. The pin stays at 0 until an edge with `sampleValid` high has passed. Normal control applies after that edge.
- R4: In manual mode, after the priming phase, `mutePin` equals `manualLevel` in the same cycle. The automatic conditions, including `clockError`, have no effect in this mode.
- R5: The mode is taken from `autoMode` only at edges where `sampleValid` is 1 (1 = automatic, 0 = manual). After reset the mode is manual.
- R6: A channel counts as silent after ZERO_RUN (default 8192) consecutive strobed samples equal to zero. Cycles without a strobe neither count nor break the run. In automatic mode, `mutePin` goes high after the edge at which the last of the six channels becomes silent.
- R7: A strobed nonzero sample on any channel restarts that channel's run. In automatic mode with no fault pending, `mutePin` is 0 after that edge.
- R8: In automatic mode, `mutePin` is 1 in any cycle in which `clockError` is 1. No clock edge is needed for this.
- R9: After `clockError` falls, `mutePin` stays high in automatic mode for HOLD_STROBES (default 1024) further sample strobes. It is released after the edge carrying the last of them.
- R10: Passing through the inactive state clears all silence runs and any pending fault hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| powerDown | input | 1 | Power-down control bit; 1 floats the pin |
| powerUpDone | input | 1 | High once the power-up sequence has finished |
| autoMode | input | 1 | Requested mode: 1 automatic, 0 manual |
| manualLevel | input | 1 | Pin level used in manual mode |
| sampleData | input | NUM_CH*SAMPLE_W (144) | Channel samples; channel k occupies bits k*SAMPLE_W upward |
| sampleValid | input | 1 | Strobe qualifying `sampleData` |
| clockError | input | 1 | Serial port clock-fault flag |
| mutePin | output | 1 | Pin value |
| mutePinOe | output | 1 | Pin output enable; 0 means high impedance |

## Verification
The bench targets the off-by-one edges of both counters. A silence detector that fires one strobe early or late fails the check made just before the run completes, or the one made just after. The same holds for a fault hold released one strobe too soon or too late. Idle cycles are placed inside the silence run, so a design that counts clocks rather than strobes mutes too early.

Mode bit changes without a strobe must leave the pin unchanged. The first strobe after power-up must not yet release the primed low. A controller that does not clear its counters in power-down comes back muted and is caught on re-entry.

// File: rtl/mute_pin_pkg.sv
package mute_pin_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleTick;
    logic clearAll;
  } dpStrobe_t;

endpackage

// File: rtl/mute_pin_datapath.sv
module mute_pin_datapath
  import mute_pin_pkg::*;
#(
  parameter int NUM_CH       = 6,
  parameter int SAMPLE_W     = 24,
  parameter int ZERO_RUN     = 8192,
  parameter int HOLD_STROBES = 1024
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  input  logic                       clockError,
  output logic                       allZero,
  output logic                       faultActive
);

  localparam int RUN_W  = $clog2(ZERO_RUN + 1);
  localparam int HOLD_W = $clog2(HOLD_STROBES + 1);

  logic [NUM_CH-1:0] chanQuiet;

  // one saturating silence counter per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [RUN_W-1:0] runCnt;
    logic             isZero;

    assign isZero = (sampleData[ch*SAMPLE_W +: SAMPLE_W] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (strobe.clearAll) begin
        runCnt <= '0;
      end else if (strobe.sampleTick) begin
        if (!isZero) begin
          runCnt <= '0;
        end else if (runCnt != RUN_W'(ZERO_RUN)) begin
          runCnt <= runCnt + RUN_W'(1);
        end
      end
    end

    assign chanQuiet[ch] = (runCnt == RUN_W'(ZERO_RUN));
  end

  assign allZero = &chanQuiet;

  // fault hold: reload while the flag is up, drain on strobes afterwards
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.clearAll) begin
      holdCnt <= '0;
    end else if (clockError) begin
      holdCnt <= HOLD_W'(HOLD_STROBES);
    end else if (strobe.sampleTick && holdCnt != '0) begin
      holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

  assign faultActive = clockError | (holdCnt != '0);

endmodule

// File: rtl/mute_pin_control.sv
module mute_pin_control
  import mute_pin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      powerDown,
  input  logic      powerUpDone,
  input  logic      autoMode,
  input  logic      manualLevel,
  input  logic      sampleValid,
  input  logic      allZero,
  input  logic      faultActive,
  output dpStrobe_t strobe,
  output logic      mutePin,
  output logic      mutePinOe,
  output logic      runFlag,
  output logic      modeAuto
);

  ctrlState_t state, stateNext;
  logic       active;
  logic       autoMute;

  assign active = !powerDown && powerUpDone;

  always_comb begin
    stateNext = state;
    if (!active) begin
      stateNext = ST_OFF;
    end else begin
      case (state)
        ST_OFF:   stateNext = ST_PRIME;
        ST_PRIME: stateNext = sampleValid ? ST_RUN : ST_PRIME;
        ST_RUN:   stateNext = ST_RUN;
        default:  stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_OFF;
    end else begin
      state <= stateNext;
    end
  end

  // mode is re-sampled only on sample strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeAuto <= 1'b0;
    end else if (sampleValid) begin
      modeAuto <= autoMode;
    end
  end

  assign strobe.sampleTick = sampleValid;
  assign strobe.clearAll   = (state == ST_OFF);

  assign autoMute  = allZero | faultActive;
  assign runFlag   = (state == ST_RUN);
  assign mutePinOe = (state != ST_OFF);
  assign mutePin   = runFlag & (modeAuto ? autoMute : manualLevel);

endmodule

// File: rtl/mute_pin_ctrl.sv
module mute_pin_ctrl
  import mute_pin_pkg::*;
#(
  parameter int NUM_CH       = 6,
  parameter int SAMPLE_W     = 24,
  parameter int ZERO_RUN     = 8192,
  parameter int HOLD_STROBES = 1024
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       powerDown,
  input  logic                       powerUpDone,
  input  logic                       autoMode,
  input  logic                       manualLevel,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  input  logic                       sampleValid,
  input  logic                       clockError,
  output logic                       mutePin,
  output logic                       mutePinOe
);

  dpStrobe_t strobe;
  logic      allZero;
  logic      faultActive;
  logic      runFlag;
  logic      modeAuto;

  mute_pin_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .powerDown   (powerDown),
    .powerUpDone (powerUpDone),
    .autoMode    (autoMode),
    .manualLevel (manualLevel),
    .sampleValid (sampleValid),
    .allZero     (allZero),
    .faultActive (faultActive),
    .strobe      (strobe),
    .mutePin     (mutePin),
    .mutePinOe   (mutePinOe),
    .runFlag     (runFlag),
    .modeAuto    (modeAuto)
  );

  mute_pin_datapath #(
    .NUM_CH       (NUM_CH),
    .SAMPLE_W     (SAMPLE_W),
    .ZERO_RUN     (ZERO_RUN),
    .HOLD_STROBES (HOLD_STROBES)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sampleData  (sampleData),
    .clockError  (clockError),
    .allZero     (allZero),
    .faultActive (faultActive)
  );

endmodule

// File: rtl/mute_pin_checker.sv
module mute_pin_checker (
  input logic clk,
  input logic rstN,
  input logic powerDown,
  input logic powerUpDone,
  input logic manualLevel,
  input logic sampleValid,
  input logic clockError,
  input logic mutePin,
  input logic mutePinOe,
  input logic runFlag,
  input logic modeAuto
);

  p_float_until_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    !powerUpDone |=> !mutePinOe);

  p_pin_low_when_float_r1: assert property (@(posedge clk) disable iff (!rstN)
    !mutePinOe |-> !mutePin);

  p_float_in_powerdown_r2: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !mutePinOe);

  p_primed_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mutePinOe) |-> !mutePin);

  p_manual_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && !modeAuto) |-> (mutePin == manualLevel));

  p_mode_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(modeAuto));

  p_fault_mutes_r8: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && modeAuto && clockError) |-> mutePin);

endmodule

bind mute_pin_ctrl mute_pin_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .powerDown   (powerDown),
  .powerUpDone (powerUpDone),
  .manualLevel (manualLevel),
  .sampleValid (sampleValid),
  .clockError  (clockError),
  .mutePin     (mutePin),
  .mutePinOe   (mutePinOe),
  .runFlag     (runFlag),
  .modeAuto    (modeAuto)
);

// File: tb/tb_mute_pin_ctrl.sv
`timescale 1ns/1ps
module tb_mute_pin_ctrl;

  localparam int NUM_CH       = 6;
  localparam int SAMPLE_W     = 24;
  localparam int ZERO_RUN     = 8192;
  localparam int HOLD_STROBES = 1024;
  localparam int DATA_W       = NUM_CH * SAMPLE_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              powerDown = 1'b1;
  logic              powerUpDone = 1'b0;
  logic              autoMode = 1'b0;
  logic              manualLevel = 1'b0;
  logic [DATA_W-1:0] sampleData = '1;
  logic              sampleValid = 1'b0;
  logic              clockError = 1'b0;
  logic              mutePin;
  logic              mutePinOe;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mute_pin_ctrl dut (
    .clk         (clk),
    .rstN        (rstN),
    .powerDown   (powerDown),
    .powerUpDone (powerUpDone),
    .autoMode    (autoMode),
    .manualLevel (manualLevel),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .clockError  (clockError),
    .mutePin     (mutePin),
    .mutePinOe   (mutePinOe)
  );

  // vector: {powerDown, powerUpDone, autoMode, manualLevel, sampleValid, expOe, expPin}
  localparam logic [6:0] VECS [15] = '{
    7'b1_0_0_0_0_0_0,  // R2 off
    7'b0_0_0_1_0_0_0,  // R1 power-up not done
    7'b1_1_0_1_0_0_0,  // R2 overrides done
    7'b0_1_0_1_0_1_0,  // R3 primed low
    7'b0_1_0_1_0_1_0,  // R3 still primed, no strobe
    7'b0_1_0_1_1_1_1,  // R4 strobe -> run, manual high
    7'b0_1_0_0_0_1_0,  // R4 manual low
    7'b0_1_1_1_0_1_1,  // R5 auto requested, no strobe: still manual
    7'b0_1_1_0_0_1_0,  // R5 still manual
    7'b0_1_1_1_1_1_0,  // R5 strobe -> auto, data live
    7'b0_1_1_1_0_1_0,  // R4 manual level ignored in auto
    7'b1_1_1_1_0_0_0,  // R2 power down again
    7'b0_1_1_1_0_1_0,  // R3 primed low
    7'b0_1_1_1_1_1_0,  // R3 run, auto, no mute
    7'b0_0_0_0_0_0_0   // R1 power-up lost
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic expOe, logic expPin);
    compared++;
    if (mutePinOe !== expOe || mutePin !== expPin) begin
      mismatched++;
      $display("FAIL %s: oe=%b pin=%b expected oe=%b pin=%b", req, mutePinOe, mutePin, expOe, expPin);
    end
  endtask

  task automatic strobes(int n);
    sampleValid = 1'b1;
    for (int i = 0; i < n; i++) tick();
    sampleValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      finishRun();
    end
  end

  initial begin
    // reset state (R1)
    tick();
    tick();
    check("R1 reset", 1'b0, 1'b0);
    rstN = 1'b1;
    tick();
    check("R1 after reset", 1'b0, 1'b0);

    // table walk
    for (int v = 0; v < 15; v++) begin
      {powerDown, powerUpDone, autoMode, manualLevel, sampleValid} = VECS[v][6:2];
      tick();
      check($sformatf("R1-table vec %0d", v), VECS[v][1], VECS[v][0]);
    end
    sampleValid = 1'b0;

    // R6 / R7 silence detection
    powerDown = 1'b0; powerUpDone = 1'b1; autoMode = 1'b1; sampleData = '0;
    tick();                     // prime
    check("R3 prime", 1'b1, 1'b0);
    strobes(1);                 // run, auto, run length 1
    check("R3 first strobe", 1'b1, 1'b0);
    strobes(ZERO_RUN - 2);
    check("R6 one short", 1'b1, 1'b0);
    tick(); tick(); tick();     // idle cycles do not count
    check("R6 idle no count", 1'b1, 1'b0);
    strobes(1);
    check("R6 run complete", 1'b1, 1'b1);
    sampleData[2*SAMPLE_W +: SAMPLE_W] = 24'h000005;
    strobes(1);
    check("R7 nonzero releases", 1'b1, 1'b0);
    sampleData = '0;
    strobes(ZERO_RUN - 1);
    check("R7 restarted run short", 1'b1, 1'b0);
    strobes(1);
    check("R6 restarted run done", 1'b1, 1'b1);

    // R8 / R9 clock fault
    sampleData = '1;
    strobes(1);
    check("R7 live data", 1'b1, 1'b0);
    clockError = 1'b1;
    #1;
    check("R8 immediate", 1'b1, 1'b1);
    tick();
    check("R8 held fault", 1'b1, 1'b1);
    clockError = 1'b0;
    tick();
    check("R9 no strobe", 1'b1, 1'b1);
    strobes(HOLD_STROBES - 1);
    check("R9 one short", 1'b1, 1'b1);
    strobes(1);
    check("R9 released", 1'b1, 1'b0);

    // R4 manual mode ignores fault
    autoMode = 1'b0; manualLevel = 1'b0;
    strobes(1);
    clockError = 1'b1;
    tick();
    check("R4 fault ignored manual", 1'b1, 1'b0);
    clockError = 1'b0;
    autoMode = 1'b1;
    strobes(1);                 // back to auto, hold pending
    check("R9 hold in auto", 1'b1, 1'b1);

    // R10 power-down clears hold
    powerDown = 1'b1;
    tick(); tick();
    check("R2 off", 1'b0, 1'b0);
    powerDown = 1'b0;
    tick();
    strobes(1);
    check("R10 hold cleared", 1'b1, 1'b0);

    // R10 power-down clears silence runs
    sampleData = '0;
    strobes(ZERO_RUN);
    check("R6 silent again", 1'b1, 1'b1);
    powerDown = 1'b1;
    tick(); tick();
    powerDown = 1'b0;
    tick();
    strobes(1);
    check("R10 runs cleared", 1'b1, 1'b0);

    finishRun();
  end

endmodule